// File: doc/BRIEF.md
# Bidirectional Universal Shift Register

This block is a four-bit register whose behaviour on each rising clock edge is chosen by a two-bit mode input. It can keep its contents, move them one place toward the low-order end, move them one place toward the high-order end, or take a full word from a parallel input. Each shift direction has its own serial input bit. Every stored bit drives the parallel output. The high-order position is named A and the low-order position is named D. This is the reverse of the common bit-0-first labelling, so the serial bit for a right shift enters at the most significant bit.

An active-low clear empties the register at once, whatever the clock and mode are doing. The clear is released through a synchronizer, so the register does not act on the edge where the clear goes away, or on the edge after it. To use the block as a rotator, connect the low-order output back to the right-shift serial input and hold the mode at shift right. The block is written for a width parameter that defaults to four.

Top module: `usr_shift4`

## Requirements
- R1: With mode 2'b00, the output `q` keeps its value across a rising clock edge.
- R2: With mode 2'b01 (shift right), a rising edge sets `q[W-1]` to `ser_right` and sets each `q[i]` to the old `q[i+1]`. The old `q[0]` is lost.
- R3: With mode 2'b10 (shift left), a rising edge sets `q[0]` to `ser_left` and sets each `q[i]` to the old `q[i-1]`. The old `q[W-1]` is lost.
- R4: With mode 2'b11 (load), a rising edge copies `par_in` into `q`. `par_in[W-1]` is position A, the high-order bit.
- R5: When `q[0]` is fed back into `ser_right` and the mode is held at shift right, the value 4'b1000 steps through 0100, 0010 and 0001, then returns to 1000.
- R6: While `clr_n` is low, `q` is 0. This takes effect at once when `clr_n` falls, without waiting for a clock edge, and it overrides every mode.
- R7: After `clr_n` rises, `q` stays 0 through the next two rising edges. The selected mode first acts on the third rising edge.
- R8: Over a long run of mixed modes with random serial and parallel data, `q` follows the per-mode rules of R1 to R4 on every edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. All mode actions happen on its rising edge. |
| clr_n | input | 1 | Asynchronous active-low clear. Its release is synchronized inside the block. |
| mode | input | 2 | 00 hold, 01 shift right, 10 shift left, 11 parallel load |
| ser_right | input | 1 | Serial bit that enters the high-order end on a right shift |
| ser_left | input | 1 | Serial bit that enters the low-order end on a left shift |
| par_in | input | W | Parallel load word. Bit W-1 is position A, the high-order bit. |
| q | output | W | Stored word. Bit W-1 is position A and bit 0 is position D. |

## Verification
The hardest cases to reach from the ports involve the clear. One is the clear falling partway through a clock period. The other is the two-edge quiet window after the clear is released.
- For the first, the bench drops `clr_n` a short time after a falling clock edge and reads `q` before the next rising edge.
- For the second, it releases the clear with load mode selected and a nonzero word waiting on `par_in`. It then checks that the word shows up only after the third rising edge.

A long mixed-mode sequence also brings out the reversed bit ordering. It mixes both shift directions with distinct serial bits, and it runs the rotate loop from the output back to `ser_right`.

// File: rtl/usr_pkg.sv
package usr_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD = 2'b00,
    MODE_SHR  = 2'b01,
    MODE_SHL  = 2'b10,
    MODE_LOAD = 2'b11
  } usr_mode_e;
endpackage

// File: rtl/usr_clear_sync.sv
// Asserts the clear at once; releases it only after STAGES rising edges.
module usr_clear_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic clr_n,
  output logic run_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign run_n = chain_q[STAGES-1];
endmodule

// File: rtl/usr_next_state.sv
// Per-bit source selection. Bit W-1 is the high-order position A.
module usr_next_state #(
  parameter int W = 4
) (
  input  logic [1:0]   mode,
  input  logic         ser_right,
  input  logic         ser_left,
  input  logic [W-1:0] par_in,
  input  logic [W-1:0] cur,
  output logic [W-1:0] nxt,
  output logic         upd_en
);
  import usr_pkg::*;

  usr_mode_e sel;
  assign sel    = usr_mode_e'(mode);
  assign upd_en = (sel != MODE_HOLD);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic from_hi;  // source on a right shift
    logic from_lo;  // source on a left shift
    if (i == W-1) begin : g_top
      assign from_hi = ser_right;
    end else begin : g_mid_hi
      assign from_hi = cur[i+1];
    end
    if (i == 0) begin : g_bot
      assign from_lo = ser_left;
    end else begin : g_mid_lo
      assign from_lo = cur[i-1];
    end

    always_comb begin
      unique case (sel)
        MODE_SHR:  nxt[i] = from_hi;
        MODE_SHL:  nxt[i] = from_lo;
        MODE_LOAD: nxt[i] = par_in[i];
        default:   nxt[i] = cur[i];
      endcase
    end
  end
endmodule

// File: rtl/usr_state_reg.sv
module usr_state_reg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         run_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge run_n) begin
    if (!run_n)  q <= '0;
    else if (en) q <= d;
  end
endmodule

// File: rtl/usr_shift4.sv
module usr_shift4 #(
  parameter int W           = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic [1:0]   mode,
  input  logic         ser_right,
  input  logic         ser_left,
  input  logic [W-1:0] par_in,
  output logic [W-1:0] q
);
  logic         run_n;
  logic         upd_en;
  logic [W-1:0] nxt;

  usr_clear_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .clr_n (clr_n),
    .run_n (run_n)
  );

  usr_next_state #(.W(W)) u_next (
    .mode      (mode),
    .ser_right (ser_right),
    .ser_left  (ser_left),
    .par_in    (par_in),
    .cur       (q),
    .nxt       (nxt),
    .upd_en    (upd_en)
  );

  usr_state_reg #(.W(W)) u_reg (
    .clk   (clk),
    .run_n (run_n),
    .en    (upd_en),
    .d     (nxt),
    .q     (q)
  );
endmodule

// File: rtl/usr_shift4_chk.sv
module usr_shift4_chk #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         clr_n,
  input logic         run_n,
  input logic [1:0]   mode,
  input logic         ser_right,
  input logic         ser_left,
  input logic [W-1:0] par_in,
  input logic [W-1:0] q
);
  p_hold_r1: assert property (@(posedge clk) disable iff (!run_n)
    (mode == 2'b00) |=> $stable(q));

  p_shift_right_r2: assert property (@(posedge clk) disable iff (!run_n)
    (mode == 2'b01) |=> (q == {$past(ser_right), $past(q[W-1:1])}));

  p_shift_left_r3: assert property (@(posedge clk) disable iff (!run_n)
    (mode == 2'b10) |=> (q == {$past(q[W-2:0]), $past(ser_left)}));

  p_load_r4: assert property (@(posedge clk) disable iff (!run_n)
    (mode == 2'b11) |=> (q == $past(par_in)));

  p_clear_r6: assert property (@(posedge clk)
    (!clr_n) |-> (q == '0));

  p_release_quiet_r7: assert property (@(posedge clk) disable iff (!clr_n)
    (!run_n) |=> (q == '0));
endmodule

bind usr_shift4 usr_shift4_chk #(.W(W)) u_chk (
  .clk       (clk),
  .clr_n     (clr_n),
  .run_n     (run_n),
  .mode      (mode),
  .ser_right (ser_right),
  .ser_left  (ser_left),
  .par_in    (par_in),
  .q         (q)
);

// File: tb/usr_shift4_test.sv
`timescale 1ns/1ps
module usr_shift4_test;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         clr_n;
  logic [1:0]   mode;
  logic         ser_right;
  logic         ser_left;
  logic [W-1:0] par_in;
  logic [W-1:0] q;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;  // 125 MHz

  usr_shift4 #(.W(W)) uut (
    .clk(clk), .clr_n(clr_n), .mode(mode), .ser_right(ser_right),
    .ser_left(ser_left), .par_in(par_in), .q(q)
  );

  task automatic check(input string req, input logic [W-1:0] got,
                       input logic [W-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: q=%b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  function automatic logic [W-1:0] model(input logic [W-1:0] cur,
      input logic [1:0] m, input logic sr, input logic sl,
      input logic [W-1:0] p);
    case (m)
      2'b01:   return {sr, cur[W-1:1]};
      2'b10:   return {cur[W-2:0], sl};
      2'b11:   return p;
      default: return cur;
    endcase
  endfunction

  // drive on falling edge, sample 1 ns after the next rising edge
  task automatic step(input logic [1:0] m, input logic sr, input logic sl,
                      input logic [W-1:0] p);
    @(negedge clk);
    mode = m; ser_right = sr; ser_left = sl; par_in = p;
    @(posedge clk);
    #1;
  endtask

  task automatic do_release(input string req);
    @(negedge clk);
    mode = 2'b11; par_in = 4'b1011; clr_n = 1'b1;
    @(posedge clk); #1; check({req, " edge1 quiet"}, q, 4'b0000);
    @(posedge clk); #1; check({req, " edge2 quiet"}, q, 4'b0000);
    @(posedge clk); #1; check({req, " edge3 acts"}, q, 4'b1011);
  endtask

  task automatic t_reset();
    clr_n = 1'b0; mode = 2'b11; ser_right = 1'b1; ser_left = 1'b1;
    par_in = 4'b1111;
    repeat (3) @(posedge clk);
    #1 check("R6 reset state", q, 4'b0000);
  endtask

  task automatic t_release();
    do_release("R7");
  endtask

  task automatic t_load();
    step(2'b11, 1'b0, 1'b0, 4'b1000); check("R4 load 1000", q, 4'b1000);
    step(2'b11, 1'b1, 1'b1, 4'b0110); check("R4 load 0110", q, 4'b0110);
  endtask

  task automatic t_hold();
    step(2'b11, 1'b0, 1'b0, 4'b1001);
    step(2'b00, 1'b1, 1'b1, 4'b0110); check("R1 hold ignores inputs", q, 4'b1001);
    step(2'b00, 1'b0, 1'b0, 4'b1111); check("R1 hold again", q, 4'b1001);
  endtask

  task automatic t_shr();
    step(2'b11, 1'b0, 1'b0, 4'b0011);
    step(2'b01, 1'b1, 1'b0, 4'b0000); check("R2 shr in 1", q, 4'b1001);
    step(2'b01, 1'b0, 1'b1, 4'b1111); check("R2 shr in 0", q, 4'b0100);
    step(2'b01, 1'b1, 1'b1, 4'b0000); check("R2 shr in 1 again", q, 4'b1010);
  endtask

  task automatic t_shl();
    step(2'b11, 1'b0, 1'b0, 4'b1100);
    step(2'b10, 1'b0, 1'b1, 4'b0000); check("R3 shl in 1", q, 4'b1001);
    step(2'b10, 1'b1, 1'b0, 4'b1111); check("R3 shl in 0", q, 4'b0010);
    step(2'b10, 1'b0, 1'b1, 4'b0000); check("R3 shl in 1 again", q, 4'b0101);
  endtask

  task automatic t_rotate();
    logic [W-1:0] seq [4] = '{4'b0100, 4'b0010, 4'b0001, 4'b1000};
    step(2'b11, 1'b0, 1'b0, 4'b1000);
    for (int k = 0; k < 4; k++) begin
      step(2'b01, q[0], 1'b0, 4'b0000);
      check("R5 rotate", q, seq[k]);
    end
  endtask

  task automatic t_async_clear();
    step(2'b11, 1'b0, 1'b0, 4'b1110);
    @(negedge clk);
    mode = 2'b11; par_in = 4'b0111;
    #1 clr_n = 1'b0;
    #1 check("R6 async clear mid-cycle", q, 4'b0000);
    @(posedge clk); #1 check("R6 clear overrides load", q, 4'b0000);
    do_release("R7 after mid-cycle clear");
  endtask

  task automatic t_random();
    logic [W-1:0] exp;
    exp = q;
    for (int k = 0; k < 3000; k++) begin
      logic [1:0] m;
      logic sr, sl;
      logic [W-1:0] p;
      m = 2'($urandom); sr = 1'($urandom); sl = 1'($urandom);
      p = W'($urandom);
      step(m, sr, sl, p);
      exp = model(exp, m, sr, sl, p);
      check("R8 random mixed modes", q, exp);
    end
  endtask

  initial begin
    t_reset();
    t_release();
    t_load();
    t_hold();
    t_shr();
    t_shl();
    t_rotate();
    t_async_clear();
    t_random();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule